// File: doc/BRIEF.md
# Microcode Sequencer with Single-Step Debug

This block runs a signal-processing program held in a 512-entry store of 64-bit instruction words. A tick starts one program pass at address zero. The pass executes one instruction per clock, in address order, until it moves past the last entry. The block then idles and waits for the next tick. Each word is split into an opcode, a destination address and three source addresses. The sources are read from a 10-bit register space. That space holds read-only constants, an accumulator, a condition register and general-purpose registers. The operand values and the opcode go to an attached arithmetic unit. Its result, saturation flag and condition code come back in the same cycle.

Opcode 15 performs no arithmetic. It tests a condition value against a mask and, when the test hits, jumps forward over a counted number of instructions. A debug word controls and observes the pass:
- Single-step mode holds the sequencer still until a step bit is written.
- The debug word shows the current address and the condition code.
- It records the address of the first instruction that saturated.

Software loads the program and the registers through simple write ports. It reads any register through a read port.

Top module: `ucode_sequencer`

## Requirements
- R1: Each 64-bit word is split into fields. Bits 19:10 are source X and bits 9:0 are source Y. Bits 55:52 are the opcode, bits 51:42 are the destination and bits 41:32 are source A. The three source values and the opcode drive the arithmetic-unit outputs.
- R2: Reads of the register space return the following:
  - Addresses 0x40..0x55 return fixed constants, for example 0x40=0, 0x41=1, 0x42=2, 0x43=3, 0x45=8, 0x4E=0x80000000, 0x4F=0x7FFFFFFF, 0x50=0xFFFFFFFF, 0x53=0x4F1BBCDC, 0x54=0x5A7EF9DB and 0x55=0x00100000.
  - 0x56 returns the accumulator and 0x57 returns the condition register.
  - 0x100+n (n = 0..255) returns 32-bit general-purpose register n.
  - Every other address returns 0.
- R3: A write to any address outside 0x100..0x1FF is dropped. This applies to the constants in particular, whether the write comes from software or from an instruction.
- R4: In the idle state, a high tick starts a pass at address 0 and raises busy. The pass executes one instruction per cycle and ends after address 511, with busy low and the address back at 0. A tick while busy is ignored.
- R5: An executed instruction other than opcode 15 writes the arithmetic result to its destination. It also loads the result into the accumulator, and loads the 5-bit condition code into the condition register.
- R6: Opcode 15 writes nothing. It is taken when (value of A AND value of Y) is nonzero. When taken, the next address is current + 1 + value of X. If that address is beyond 511, the pass ends.
- R7: Debug bit 15 selects single-step mode. In that mode an instruction executes only while step bit 14 is set, and executing it clears bit 14.
- R8: Debug read-back shows the current address in bits 8:0 and the condition register's low 5 bits in bits 13:9.
- R9: Debug bit 25 is set by the first saturating instruction, and bits 24:16 capture that instruction's address. Later saturations leave both unchanged. Writing 1 to bit 25 clears the flag, unless a saturation occurs in that same cycle.
- R10: After reset: busy is low, the debug word is 0, and all general-purpose registers, the accumulator and the condition register are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Starts a program pass when idle |
| prog_we | input | 1 | Program store write enable |
| prog_addr | input | 9 | Program store write address |
| prog_data | input | 64 | Instruction word to store |
| host_we | input | 1 | Software register write enable |
| host_addr | input | 10 | Software register write address |
| host_wdata | input | 32 | Software register write data |
| host_raddr | input | 10 | Software register read address |
| host_rdata | output | 32 | Register value at host_raddr |
| dbg_we | input | 1 | Debug word write enable |
| dbg_wdata | input | 32 | Debug word write data |
| dbg_rdata | output | 32 | Debug word read-back |
| busy | output | 1 | High while a pass is in progress |
| alu_op | output | 4 | Opcode of the current instruction |
| alu_a | output | 32 | Value of source A |
| alu_x | output | 32 | Value of source X |
| alu_y | output | 32 | Value of source Y |
| alu_result | input | 32 | Result from the arithmetic unit |
| alu_cc | input | 5 | Condition code from the arithmetic unit |
| alu_sat | input | 1 | Saturation indication from the arithmetic unit |

## Verification
The assertions assume that reset is held low from time zero until the first edges have passed. They also assume that a debug write affects only the cycle after it. In particular, a step bit is not rewritten on the same edge at which the bound check expects it to clear. The stimulus respects this by writing the debug word once, on a falling edge, and then letting several clocks pass before it samples or writes again. The arithmetic unit is a combinational stub: it adds, XORs or flags saturation according to the opcode. Its condition code is always the low five bits of its result, so every result the bench expects can be derived from the operand values alone.

// File: rtl/ucode_pkg.sv
// Shared definitions for the microcode sequencer.
// Assumes a 10-bit register address space and 32-bit data.
package ucode_pkg;

    localparam int REG_AW     = 10;
    localparam int DATA_W     = 32;
    localparam int INSTR_W    = 64;
    localparam int CC_W       = 5;

    localparam logic [REG_AW-1:0] CONST_LO = 10'h040;
    localparam logic [REG_AW-1:0] CONST_HI = 10'h055;
    localparam logic [REG_AW-1:0] ACC_ADDR = 10'h056;
    localparam logic [REG_AW-1:0] CCR_ADDR = 10'h057;
    localparam logic [3:0]        OP_SKIP  = 4'hF;

    typedef struct packed {
        logic [3:0]        op;
        logic [REG_AW-1:0] dst;
        logic [REG_AW-1:0] src_a;
        logic [REG_AW-1:0] src_x;
        logic [REG_AW-1:0] src_y;
    } ucode_instr_t;

    // Split a 64-bit word into its fields.
    function automatic ucode_instr_t split_word(input logic [INSTR_W-1:0] w);
        ucode_instr_t r;
        r.op    = w[55:52];
        r.dst   = w[51:42];
        r.src_a = w[41:32];
        r.src_x = w[19:10];
        r.src_y = w[9:0];
        return r;
    endfunction

    // Fixed value of the constant at offset idx above CONST_LO.
    function automatic logic [DATA_W-1:0] const_value(input logic [4:0] idx);
        case (idx)
            5'd0:  return 32'h0000_0000;
            5'd1:  return 32'h0000_0001;
            5'd2:  return 32'h0000_0002;
            5'd3:  return 32'h0000_0003;
            5'd4:  return 32'h0000_0004;
            5'd5:  return 32'h0000_0008;
            5'd6:  return 32'h0000_0010;
            5'd7:  return 32'h0000_0020;
            5'd8:  return 32'h0000_0100;
            5'd9:  return 32'h0001_0000;
            5'd10: return 32'h0008_0000;
            5'd11: return 32'h1000_0000;
            5'd12: return 32'h2000_0000;
            5'd13: return 32'h4000_0000;
            5'd14: return 32'h8000_0000;
            5'd15: return 32'h7FFF_FFFF;
            5'd16: return 32'hFFFF_FFFF;
            5'd17: return 32'hFFFF_FFFE;
            5'd18: return 32'hC000_0000;
            5'd19: return 32'h4F1B_BCDC;
            5'd20: return 32'h5A7E_F9DB;
            5'd21: return 32'h0010_0000;
            default: return 32'h0000_0000;
        endcase
    endfunction

endpackage

// File: rtl/ucode_store.sv
// Program store: one write port for loading, one asynchronous read port
// for the sequencer. Assumes the store is loaded while no pass runs.
module ucode_store #(
    parameter int DEPTH = 512,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                        clk,
    input  logic                        we,
    input  logic [AW-1:0]               waddr,
    input  logic [ucode_pkg::INSTR_W-1:0] wdata,
    input  logic [AW-1:0]               raddr,
    output logic [ucode_pkg::INSTR_W-1:0] rdata
);
    logic [ucode_pkg::INSTR_W-1:0] mem [DEPTH];

    // Load one instruction word.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Fetch the word at the current address.
    assign rdata = mem[raddr];
endmodule

// File: rtl/ucode_regfile.sv
// Register space: constants, accumulator, condition register and
// general-purpose registers. NRD asynchronous read ports.
// Instruction writeback wins over a software write to the same register.
module ucode_regfile
    import ucode_pkg::*;
#(
    parameter int GPR_COUNT = 256,
    parameter int GPR_BASE  = 256,
    parameter int NRD       = 4,
    localparam int GIW      = $clog2(GPR_COUNT)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NRD-1:0][REG_AW-1:0]   rd_addr,
    output logic [NRD-1:0][DATA_W-1:0]   rd_data,
    input  logic                         wb_en,
    input  logic [REG_AW-1:0]            wb_addr,
    input  logic [DATA_W-1:0]            wb_data,
    input  logic                         host_we,
    input  logic [REG_AW-1:0]            host_addr,
    input  logic [DATA_W-1:0]            host_wdata,
    input  logic                         acc_we,
    input  logic [DATA_W-1:0]            acc_d,
    input  logic [CC_W-1:0]              ccr_d
);
    localparam logic [REG_AW-1:0] GLO = REG_AW'(GPR_BASE);
    localparam logic [REG_AW:0]   GHI = (REG_AW+1)'(GPR_BASE + GPR_COUNT);

    logic [DATA_W-1:0] gpr [GPR_COUNT];
    logic [DATA_W-1:0] acc_q;
    logic [CC_W-1:0]   ccr_q;

    function automatic logic in_gpr(input logic [REG_AW-1:0] a);
        return (a >= GLO) && ({1'b0, a} < GHI);
    endfunction

    function automatic logic [GIW-1:0] gpr_idx(input logic [REG_AW-1:0] a);
        return GIW'(a - GLO);
    endfunction

    // Update registers: software first, writeback last so it wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < GPR_COUNT; i++) gpr[i] <= '0;
            acc_q <= '0;
            ccr_q <= '0;
        end else begin
            if (host_we && in_gpr(host_addr)) gpr[gpr_idx(host_addr)] <= host_wdata;
            if (wb_en && in_gpr(wb_addr))     gpr[gpr_idx(wb_addr)]   <= wb_data;
            if (acc_we) begin
                acc_q <= acc_d;
                ccr_q <= ccr_d;
            end
        end
    end

    // One decoder per read port.
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        // Resolve the address of port p to a value.
        always_comb begin
            if (in_gpr(rd_addr[p]))
                rd_data[p] = gpr[gpr_idx(rd_addr[p])];
            else if (rd_addr[p] >= CONST_LO && rd_addr[p] <= CONST_HI)
                rd_data[p] = const_value(5'(rd_addr[p] - CONST_LO));
            else if (rd_addr[p] == ACC_ADDR)
                rd_data[p] = acc_q;
            else if (rd_addr[p] == CCR_ADDR)
                rd_data[p] = {{(DATA_W-CC_W){1'b0}}, ccr_q};
            else
                rd_data[p] = '0;
        end
    end
endmodule

// File: rtl/ucode_ctrl.sv
// Sequencer control: program address, pass start/end, skip, single-step
// and saturation capture. Assumes PC_W <= 9 so the address fits the
// debug word's address field.
module ucode_ctrl
    import ucode_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int PC_W = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic [3:0]         op,
    input  logic [DATA_W-1:0]  a_val,
    input  logic [DATA_W-1:0]  x_val,
    input  logic [DATA_W-1:0]  y_val,
    input  logic               alu_sat,
    input  logic [CC_W-1:0]    ccr_val,
    input  logic               dbg_we,
    input  logic [DATA_W-1:0]  dbg_wdata,
    output logic [PC_W-1:0]    pc,
    output logic               busy,
    output logic               exec,
    output logic               is_skip,
    output logic [DATA_W-1:0]  dbg_rdata
);
    logic            ss_mode, step_pend, sat_flag;
    logic [PC_W-1:0] sat_addr;
    logic [32:0]     adv;
    logic            pass_end, sat_set, sat_clr;

    assign exec     = busy && (!ss_mode || step_pend);
    assign is_skip  = (op == OP_SKIP);
    assign sat_clr  = dbg_we && dbg_wdata[25];
    assign sat_set  = exec && !is_skip && alu_sat && (!sat_flag || sat_clr);
    assign pass_end = (adv >= 33'(DEPTH));

    // Next address: one ahead, or past the skipped block.
    always_comb begin
        if (is_skip && |(a_val & y_val))
            adv = 33'(pc) + 33'd1 + {1'b0, x_val};
        else
            adv = 33'(pc) + 33'd1;
    end

    // Address and run state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc   <= '0;
            busy <= 1'b0;
        end else if (!busy) begin
            if (tick) busy <= 1'b1;
            pc <= '0;
        end else if (exec) begin
            if (pass_end) begin
                busy <= 1'b0;
                pc   <= '0;
            end else begin
                pc <= PC_W'(adv);
            end
        end
    end

    // Debug controls: mode, step request, saturation capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ss_mode   <= 1'b0;
            step_pend <= 1'b0;
            sat_flag  <= 1'b0;
            sat_addr  <= '0;
        end else begin
            if (dbg_we) begin
                ss_mode   <= dbg_wdata[15];
                step_pend <= dbg_wdata[14];
            end else if (exec && ss_mode) begin
                step_pend <= 1'b0;
            end
            if (sat_set) begin
                sat_flag <= 1'b1;
                sat_addr <= pc;
            end else if (sat_clr) begin
                sat_flag <= 1'b0;
                sat_addr <= '0;
            end
        end
    end

    // Assemble the debug read-back word.
    always_comb begin
        dbg_rdata        = '0;
        dbg_rdata[8:0]   = 9'(pc);
        dbg_rdata[13:9]  = ccr_val;
        dbg_rdata[14]    = step_pend;
        dbg_rdata[15]    = ss_mode;
        dbg_rdata[24:16] = 9'(sat_addr);
        dbg_rdata[25]    = sat_flag;
    end
endmodule

// File: rtl/ucode_sequencer.sv
// Top: program store, register space and control, with the arithmetic
// unit attached through combinational ports (result valid same cycle).
module ucode_sequencer
    import ucode_pkg::*;
#(
    parameter int PROG_DEPTH = 512,
    parameter int GPR_COUNT  = 256,
    localparam int PC_W      = $clog2(PROG_DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                prog_we,
    input  logic [PC_W-1:0]     prog_addr,
    input  logic [63:0]         prog_data,
    input  logic                host_we,
    input  logic [9:0]          host_addr,
    input  logic [31:0]         host_wdata,
    input  logic [9:0]          host_raddr,
    output logic [31:0]         host_rdata,
    input  logic                dbg_we,
    input  logic [31:0]         dbg_wdata,
    output logic [31:0]         dbg_rdata,
    output logic                busy,
    output logic [3:0]          alu_op,
    output logic [31:0]         alu_a,
    output logic [31:0]         alu_x,
    output logic [31:0]         alu_y,
    input  logic [31:0]         alu_result,
    input  logic [4:0]          alu_cc,
    input  logic                alu_sat
);
    logic [PC_W-1:0]          pc;
    logic [INSTR_W-1:0]       word;
    ucode_instr_t             ins;
    logic [3:0][REG_AW-1:0]   rd_addr;
    logic [3:0][DATA_W-1:0]   rd_data;
    logic                     exec, is_skip, wr_en;

    assign ins     = split_word(word);
    assign rd_addr = {host_raddr, ins.src_y, ins.src_x, ins.src_a};
    assign alu_op  = ins.op;
    assign alu_a   = rd_data[0];
    assign alu_x   = rd_data[1];
    assign alu_y   = rd_data[2];
    assign host_rdata = rd_data[3];
    assign wr_en   = exec && !is_skip;

    ucode_store #(.DEPTH(PROG_DEPTH)) u_store (
        .clk(clk), .we(prog_we), .waddr(prog_addr), .wdata(prog_data),
        .raddr(pc), .rdata(word)
    );

    ucode_regfile #(.GPR_COUNT(GPR_COUNT), .GPR_BASE(256), .NRD(4)) u_regs (
        .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
        .wb_en(wr_en), .wb_addr(ins.dst), .wb_data(alu_result),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .acc_we(wr_en), .acc_d(alu_result), .ccr_d(alu_cc)
    );

    ucode_ctrl #(.DEPTH(PROG_DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .tick(tick), .op(ins.op),
        .a_val(rd_data[0]), .x_val(rd_data[1]), .y_val(rd_data[2]),
        .alu_sat(alu_sat), .ccr_val(5'(u_regs.ccr_q)),
        .dbg_we(dbg_we), .dbg_wdata(dbg_wdata),
        .pc(pc), .busy(busy), .exec(exec), .is_skip(is_skip),
        .dbg_rdata(dbg_rdata)
    );
endmodule

// File: rtl/ucode_sequencer_checker.sv
// Bound checker for the sequencer's externally visible control behaviour.
// Assumes reset is asserted from time zero.
module ucode_sequencer_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        dbg_we,
    input logic [31:0] dbg_wdata,
    input logic [31:0] dbg_rdata
);
    // Idle state always reports address 0.
    assert_idle_addr_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> dbg_rdata[8:0] == 9'd0);

    // During a pass the address never moves backwards.
    assert_addr_forward_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || dbg_rdata[8:0] >= $past(dbg_rdata[8:0])));

    // Single-step mode without a step request holds the address.
    assert_step_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && dbg_rdata[15] && !dbg_rdata[14]) |=> $stable(dbg_rdata[8:0]));

    // A granted step clears its own request bit.
    assert_step_selfclear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && dbg_rdata[15] && dbg_rdata[14] && !dbg_we) |=> !dbg_rdata[14]);

    // The saturation record stays put until a clear is written.
    assert_sat_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_rdata[25] && !(dbg_we && dbg_wdata[25])) |=>
            (dbg_rdata[25] && $stable(dbg_rdata[24:16])));
endmodule

bind ucode_sequencer ucode_sequencer_checker u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy),
    .dbg_we(dbg_we), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata)
);

// File: tb/ucode_sequencer_test.sv
// Bench: stub arithmetic unit, vector table of single-instruction
// programs, then directed tests for reset, skip, single-step, saturation.
module ucode_sequencer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        prog_we = 1'b0;
    logic [8:0]  prog_addr = '0;
    logic [63:0] prog_data = '0;
    logic        host_we = 1'b0;
    logic [9:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [9:0]  host_raddr = '0;
    logic [31:0] host_rdata;
    logic        dbg_we = 1'b0;
    logic [31:0] dbg_wdata = '0;
    logic [31:0] dbg_rdata;
    logic        busy;
    logic [3:0]  alu_op;
    logic [31:0] alu_a, alu_x, alu_y, alu_result;
    logic [4:0]  alu_cc;
    logic        alu_sat;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    // Stub arithmetic unit: op1 = A^X, otherwise A+X+Y; op2 saturates.
    always_comb begin
        alu_result = (alu_op == 4'h1) ? (alu_a ^ alu_x) : (alu_a + alu_x + alu_y);
        alu_sat    = (alu_op == 4'h2);
        alu_cc     = alu_result[4:0];
    end

    ucode_sequencer uut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .prog_we(prog_we), .prog_addr(prog_addr), .prog_data(prog_data),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_raddr(host_raddr), .host_rdata(host_rdata),
        .dbg_we(dbg_we), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
        .busy(busy), .alu_op(alu_op), .alu_a(alu_a), .alu_x(alu_x), .alu_y(alu_y),
        .alu_result(alu_result), .alu_cc(alu_cc), .alu_sat(alu_sat)
    );

    // Watchdog: counts as a failed check and still reports.
    initial begin
        #1500000;
        fails++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    function automatic logic [63:0] mk(input logic [3:0] op, input logic [9:0] dst,
                                       input logic [9:0] a, input logic [9:0] x,
                                       input logic [9:0] y);
        return {8'h00, op, dst, a, 12'h000, x, y};
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic put(input int addr, input logic [63:0] w);
        @(negedge clk);
        prog_we = 1'b1; prog_addr = 9'(addr); prog_data = w;
        @(negedge clk);
        prog_we = 1'b0;
    endtask

    task automatic load_nops();
        @(negedge clk);
        for (int i = 0; i < 512; i++) begin
            prog_we = 1'b1; prog_addr = 9'(i); prog_data = '0;
            @(negedge clk);
        end
        prog_we = 1'b0;
    endtask

    task automatic hwrite(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic hread(input logic [9:0] a, output logic [31:0] d);
        host_raddr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic dwrite(input logic [31:0] d);
        @(negedge clk);
        dbg_we = 1'b1; dbg_wdata = d;
        @(negedge clk);
        dbg_we = 1'b0;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
    endtask

    task automatic run_pass();
        pulse_tick();
        wait_idle();
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // {op, A, X, Y, expected value at 0x100}
    localparam logic [65:0] VEC [6] = '{
        {4'h0, 10'h041, 10'h042, 10'h043, 32'h0000_0006},
        {4'h0, 10'h04F, 10'h041, 10'h040, 32'h8000_0000},
        {4'h1, 10'h050, 10'h04E, 10'h040, 32'h7FFF_FFFF},
        {4'h0, 10'h101, 10'h045, 10'h040, 32'h0000_123C},
        {4'h0, 10'h010, 10'h041, 10'h053, 32'h4F1B_BCDD},
        {4'h0, 10'h055, 10'h054, 10'h040, 32'h5A8E_F9DB}
    };

    logic [31:0] v;

    initial begin
        cycles(3);
        @(negedge clk) rst_n = 1'b1;
        // R10: reset state
        check("R10 busy after reset", {31'b0, busy}, 32'd0);
        check("R10 debug word after reset", dbg_rdata, 32'd0);
        hread(10'h100, v); check("R10 gpr0 after reset", v, 32'd0);
        hread(10'h056, v); check("R10 acc after reset", v, 32'd0);

        load_nops();
        hwrite(10'h101, 32'h0000_1234);

        // R1 R2 R5: vector table of one-instruction programs
        for (int i = 0; i < 6; i++) begin
            put(0, mk(VEC[i][65:62], 10'h100, VEC[i][61:52], VEC[i][51:42], VEC[i][41:32]));
            run_pass();
            hread(10'h100, v);
            check($sformatf("R1 R2 R5 vector %0d result", i), v, VEC[i][31:0]);
        end
        check("R4 idle after pass", {31'b0, busy}, 32'd0);
        check("R4 address back at 0", {23'b0, dbg_rdata[8:0]}, 32'd0);

        // R3: software and instruction writes to constants are dropped
        hwrite(10'h041, 32'hDEAD_BEEF);
        hread(10'h041, v); check("R3 host write to constant", v, 32'd1);
        put(0, mk(4'h0, 10'h04F, 10'h041, 10'h040, 10'h040));
        run_pass();
        hread(10'h04F, v); check("R3 instruction write to constant", v, 32'h7FFF_FFFF);

        // R6: taken skip over two instructions
        load_nops();
        for (int r = 2; r < 7; r++) hwrite(10'(10'h100 + r), 32'd0);
        put(0, mk(4'h0, 10'h102, 10'h041, 10'h040, 10'h040));
        put(1, mk(4'hF, 10'h106, 10'h041, 10'h042, 10'h041));
        put(2, mk(4'h0, 10'h103, 10'h042, 10'h043, 10'h040));
        put(3, mk(4'h0, 10'h104, 10'h042, 10'h043, 10'h040));
        put(4, mk(4'h0, 10'h105, 10'h043, 10'h044, 10'h040));
        run_pass();
        hread(10'h103, v); check("R6 taken skip leaves first skipped", v, 32'd0);
        hread(10'h104, v); check("R6 taken skip leaves second skipped", v, 32'd0);
        hread(10'h105, v); check("R6 execution resumes after skip", v, 32'd7);
        hread(10'h106, v); check("R6 skip writes nothing", v, 32'd0);

        // R6: mask misses, skip not taken
        put(1, mk(4'hF, 10'h106, 10'h041, 10'h042, 10'h042));
        run_pass();
        hread(10'h103, v); check("R6 untaken skip runs next", v, 32'd5);

        // R6: count beyond the end finishes the pass
        load_nops();
        put(0, mk(4'hF, 10'h100, 10'h041, 10'h050, 10'h041));
        put(1, mk(4'h0, 10'h106, 10'h041, 10'h040, 10'h040));
        pulse_tick();
        cycles(3);
        check("R6 long skip ends pass", {31'b0, busy}, 32'd0);
        hread(10'h106, v); check("R6 long skip suppresses rest", v, 32'd0);

        // R7 R8: single-step
        load_nops();
        hwrite(10'h102, 32'd0);
        put(0, mk(4'h0, 10'h102, 10'h041, 10'h040, 10'h040));
        dwrite(32'h0000_8000);
        pulse_tick();
        cycles(4);
        check("R7 held in step mode busy", {31'b0, busy}, 32'd1);
        check("R7 R8 held at address 0", dbg_rdata, 32'h0000_8000);
        hread(10'h102, v); check("R7 nothing executed yet", v, 32'd0);
        dwrite(32'h0000_C000);
        cycles(3);
        check("R7 R8 one step taken, bit cleared, cc shown", dbg_rdata, 32'h0000_8201);
        hread(10'h102, v); check("R5 stepped result", v, 32'd1);
        hread(10'h056, v); check("R5 accumulator", v, 32'd1);
        hread(10'h057, v); check("R2 R5 condition register", v, 32'd1);
        pulse_tick();
        cycles(2);
        check("R4 tick while busy ignored", {23'b0, dbg_rdata[8:0]}, 32'd1);
        dwrite(32'h0000_0000);
        wait_idle();
        check("R7 leaving step mode finishes pass", {31'b0, busy}, 32'd0);

        // R9: saturation capture
        load_nops();
        put(3, mk(4'h2, 10'h000, 10'h040, 10'h040, 10'h040));
        put(6, mk(4'h2, 10'h000, 10'h040, 10'h040, 10'h040));
        run_pass();
        check("R9 first saturating address kept", dbg_rdata & 32'h03FF_0000, 32'h0203_0000);
        dwrite(32'h0200_0000);
        check("R9 clear by writing bit 25", dbg_rdata & 32'h03FF_0000, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule